// File: doc/BRIEF.md
# Quantum-Limited Shared Bus Arbiter

This block decides which of several masters owns a shared synchronous bus. The masters are a processor instruction-fetch port, a processor data port and a parameterised number of DMA engines. Every grant is split into two phases. First comes a handshake phase of a configurable number of cycles, during which the bus is reserved but carries nothing useful. Then comes a payload phase, capped by a configurable quantum. When the payload phase ends, the bus is arbitrated again.

The processor ports have fixed transfer lengths: a fetch needs three payload cycles and a data read needs one. Each is cut short if the quantum is smaller. A DMA engine keeps the bus until it signals completion or until its quantum runs out. The data port beats every other requester. DMA engines share the middle rank in rotating order, and the fetch port has the lowest rank. Two free-running counters report how many cycles were spent in handshake and how many in payload, so software or a monitor can derive useful utilisation as payload / (payload + handshake). Cycles in which nothing is granted are counted in neither.

Top module: `quantum_bus_arbiter`

## Requirements
- R1: Starting from an idle bus, a request present in one cycle is granted in the next cycle. The grant begins with exactly cfgOverhead handshake cycles (busOverhead high), followed by payload cycles (busPayload high). When cfgOverhead is 0, the first granted cycle is already a payload cycle.
- R2: One grant never carries more payload cycles than the effective quantum. The effective quantum is cfgQuantum, except that a cfgQuantum of 0 behaves as 1.
- R3: Request bit positions are: reqVec[1] is the data port, reqVec[0] is the fetch port, and reqVec[2+k] is DMA engine k; grantVec uses the same positions. Whenever a winner is chosen, the data port beats every other requester, and any DMA engine beats the fetch port.
- R4: A fetch grant carries min(3, effective quantum) payload cycles and a data grant carries min(1, effective quantum), without any completion signal.
- R5: At most one grantVec bit is set in any cycle. A grant never changes during its handshake phase or before its last payload cycle.
- R6: dmaDone[k] high in a payload cycle of DMA engine k's grant makes that cycle the last one. dmaDone high during the handshake phase, or while the engine is not granted, has no effect.
- R7: DMA engines rotate. After engine k has been granted, the search among engines for the next pick starts at engine k+1 (wrapping to 0).
- R8: When a grant ends, its owner cannot win that arbitration. Another pending requester receives the bus in the very next cycle, with no idle cycle between. If no other requester is pending, the bus is idle for at least one cycle before the same owner can be granted again.
- R9: overheadCount rises by one for each handshake cycle and payloadCount by one for each payload cycle. Cycles with no grant change neither counter.
- R10: While rstN is low, grantVec, busOverhead and busPayload are all 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgQuantum | input | Q_W | Payload cycle cap per grant (0 behaves as 1) |
| cfgOverhead | input | O_W | Handshake cycles paid at the start of each grant |
| reqVec | input | NUM_DMA+2 | Request lines: bit 0 fetch, bit 1 data, bits 2.. DMA engines |
| dmaDone | input | NUM_DMA | Per-engine completion strobe, honoured only in its own payload cycles |
| grantVec | output | NUM_DMA+2 | One-hot grant, same bit positions as reqVec |
| busOverhead | output | 1 | Current cycle is a handshake cycle of the active grant |
| busPayload | output | 1 | Current cycle is a payload cycle of the active grant |
| overheadCount | output | CNT_W | Total handshake cycles since reset |
| payloadCount | output | CNT_W | Total payload cycles since reset |

## Verification
Several properties are checked on every cycle by assertions:
- the grant vector never has more than one bit set;
- a grant holds steady until its final payload cycle;
- the data port wins whenever it asks from an idle bus;
- a finishing owner never keeps the bus across a handover;
- a loaded payload count never exceeds the effective quantum;
- idle cycles leave both counters untouched.

Other behaviour is visible only through the bench's scenarios:
- the exact handshake and payload lengths across quantum and handshake settings;
- the order of grants among mixed requesters;
- the rotation among DMA engines;
- completion strobes being ignored during the handshake;
- the single idle cycle when a sole requester re-requests.

// File: rtl/quantum_arb_pkg.sv
package quantum_arb_pkg;

  localparam int FETCH_IDX = 0;
  localparam int DATA_IDX  = 1;
  localparam int DMA_BASE  = 2;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OVH  = 2'd1,
    PH_PAY  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_DMA   = 2'd2
  } xfer_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       loadOvh;
    logic       loadPay;
    logic       stepDown;
    logic       countOvh;
    logic       countPay;
    xfer_kind_e payKind;
  } ctl_strobe_t;

  function automatic xfer_kind_e kindOf(input logic fetchBit, input logic dataBit);
    if (dataBit)       return KIND_DATA;
    else if (fetchBit) return KIND_FETCH;
    else               return KIND_DMA;
  endfunction

endpackage

// File: rtl/qarb_picker.sv
module qarb_picker
  import quantum_arb_pkg::*;
#(
  parameter  int NUM_DMA = 2,
  localparam int NREQ    = NUM_DMA + 2,
  localparam int DMA_IW  = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1
) (
  input  logic [NREQ-1:0]   candVec,
  input  logic [DMA_IW-1:0] rrPtr,
  output logic [NREQ-1:0]   winVec,
  output logic              dmaWon,
  output logic [DMA_IW-1:0] dmaIdx
);

  logic [NUM_DMA-1:0] dmaCand;
  assign dmaCand = candVec[NREQ-1:DMA_BASE];

  // Rotating search among DMA engines, starting at rrPtr
  always_comb begin
    dmaWon = 1'b0;
    dmaIdx = '0;
    for (int k = 0; k < NUM_DMA; k++) begin
      if (!dmaWon && dmaCand[(int'(rrPtr) + k) % NUM_DMA]) begin
        dmaWon = 1'b1;
        dmaIdx = DMA_IW'((int'(rrPtr) + k) % NUM_DMA);
      end
    end
  end

  // Fixed ranks: data, then DMA group, then fetch
  always_comb begin
    winVec = '0;
    if (candVec[DATA_IDX])       winVec[DATA_IDX] = 1'b1;
    else if (dmaWon)             winVec[DMA_BASE + int'(dmaIdx)] = 1'b1;
    else if (candVec[FETCH_IDX]) winVec[FETCH_IDX] = 1'b1;
  end

endmodule

// File: rtl/qarb_control.sv
module qarb_control
  import quantum_arb_pkg::*;
#(
  parameter  int NUM_DMA = 2,
  parameter  int O_W     = 4,
  localparam int NREQ    = NUM_DMA + 2,
  localparam int DMA_IW  = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [O_W-1:0]    cfgOverhead,
  input  logic [NREQ-1:0]   reqVec,
  input  logic [NUM_DMA-1:0] dmaDone,
  input  logic              remLast,
  output ctl_strobe_t       strobe,
  output logic [NREQ-1:0]   grantVec,
  output logic              busOverhead,
  output logic              busPayload
);

  phase_e              phaseQ, phaseD;
  logic [NREQ-1:0]     grantQ, grantD;
  logic [DMA_IW-1:0]   rrPtrQ, rrPtrD;
  logic                doneHit, payEnd, arbNow;
  logic [NREQ-1:0]     candVec, winVec;
  logic                dmaWon;
  logic [DMA_IW-1:0]   dmaIdx;

  assign doneHit = (phaseQ == PH_PAY) && (|(grantQ[NREQ-1:DMA_BASE] & dmaDone));
  assign payEnd  = (phaseQ == PH_PAY) && (remLast || doneHit);
  assign arbNow  = (phaseQ == PH_IDLE) || payEnd;
  // Owner of a finishing grant is not eligible at its own handover
  assign candVec = reqVec & ((phaseQ == PH_IDLE) ? {NREQ{1'b1}} : ~grantQ);

  qarb_picker #(.NUM_DMA(NUM_DMA)) picker_i (
    .candVec (candVec),
    .rrPtr   (rrPtrQ),
    .winVec  (winVec),
    .dmaWon  (dmaWon),
    .dmaIdx  (dmaIdx)
  );

  always_comb begin
    phaseD          = phaseQ;
    grantD          = grantQ;
    rrPtrD          = rrPtrQ;
    strobe.loadOvh  = 1'b0;
    strobe.loadPay  = 1'b0;
    strobe.stepDown = 1'b0;
    strobe.countOvh = (phaseQ == PH_OVH);
    strobe.countPay = (phaseQ == PH_PAY);
    strobe.payKind  = kindOf(grantQ[FETCH_IDX], grantQ[DATA_IDX]);
    if (arbNow) begin
      if (|winVec) begin
        grantD = winVec;
        if (|winVec[NREQ-1:DMA_BASE] && dmaWon) begin
          rrPtrD = (int'(dmaIdx) == NUM_DMA - 1) ? '0 : dmaIdx + 1'b1;
        end
        if (cfgOverhead == '0) begin
          phaseD         = PH_PAY;
          strobe.loadPay = 1'b1;
          strobe.payKind = kindOf(winVec[FETCH_IDX], winVec[DATA_IDX]);
        end else begin
          phaseD         = PH_OVH;
          strobe.loadOvh = 1'b1;
        end
      end else begin
        grantD = '0;
        phaseD = PH_IDLE;
      end
    end else if (phaseQ == PH_OVH) begin
      if (remLast) begin
        phaseD         = PH_PAY;
        strobe.loadPay = 1'b1;
      end else begin
        strobe.stepDown = 1'b1;
      end
    end else begin
      strobe.stepDown = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      grantQ <= '0;
      rrPtrQ <= '0;
    end else begin
      phaseQ <= phaseD;
      grantQ <= grantD;
      rrPtrQ <= rrPtrD;
    end
  end

  assign grantVec    = grantQ;
  assign busOverhead = (phaseQ == PH_OVH);
  assign busPayload  = (phaseQ == PH_PAY);

  // R5: never more than one owner
  a_r5_one_owner: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantQ));

  // R5: grant is held until its last payload cycle
  a_r5_grant_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ != PH_IDLE && !payEnd) |=> (grantQ == $past(grantQ)));

  // R3: data port wins from an idle bus
  a_r3_data_first: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_IDLE && reqVec[DATA_IDX]) |=> grantQ[DATA_IDX]);

  // R8: finishing owner does not keep the bus
  a_r8_owner_yields: assert property (@(posedge clk) disable iff (!rstN)
    payEnd |=> ((grantQ & $past(grantQ)) == '0));

endmodule

// File: rtl/qarb_datapath.sv
module qarb_datapath
  import quantum_arb_pkg::*;
#(
  parameter  int Q_W       = 4,
  parameter  int O_W       = 4,
  parameter  int CNT_W     = 16,
  parameter  int FETCH_LEN = 3,
  parameter  int DATA_LEN  = 1,
  localparam int REM_W     = (Q_W > O_W) ? Q_W : O_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Q_W-1:0]   cfgQuantum,
  input  logic [O_W-1:0]   cfgOverhead,
  input  ctl_strobe_t      strobe,
  output logic             remLast,
  output logic [CNT_W-1:0] overheadCount,
  output logic [CNT_W-1:0] payloadCount
);

  logic [REM_W-1:0] qEff, payLimit, remQ;
  logic [CNT_W-1:0] ovhCntQ, payCntQ;

  assign qEff = (cfgQuantum == '0) ? REM_W'(1) : REM_W'(cfgQuantum);

  always_comb begin
    unique case (strobe.payKind)
      KIND_FETCH: payLimit = (REM_W'(FETCH_LEN) < qEff) ? REM_W'(FETCH_LEN) : qEff;
      KIND_DATA:  payLimit = (REM_W'(DATA_LEN)  < qEff) ? REM_W'(DATA_LEN)  : qEff;
      default:    payLimit = qEff;
    endcase
  end

  // Remaining cycles in the current phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ <= '0;
    end else if (strobe.loadOvh) begin
      remQ <= REM_W'(cfgOverhead);
    end else if (strobe.loadPay) begin
      remQ <= payLimit;
    end else if (strobe.stepDown && remQ != '0) begin
      remQ <= remQ - 1'b1;
    end
  end

  assign remLast = (remQ == REM_W'(1));

  // Utilisation counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovhCntQ <= '0;
      payCntQ <= '0;
    end else begin
      if (strobe.countOvh) ovhCntQ <= ovhCntQ + 1'b1;
      if (strobe.countPay) payCntQ <= payCntQ + 1'b1;
    end
  end

  assign overheadCount = ovhCntQ;
  assign payloadCount  = payCntQ;

  // R2: a loaded payload run is non-empty and within the quantum
  a_r2_quantum_cap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPay |=> (remQ != '0) && (remQ <= $past(qEff)));

endmodule

// File: rtl/quantum_bus_arbiter.sv
module quantum_bus_arbiter
  import quantum_arb_pkg::*;
#(
  parameter  int NUM_DMA   = 2,
  parameter  int Q_W       = 4,
  parameter  int O_W       = 4,
  parameter  int CNT_W     = 16,
  parameter  int FETCH_LEN = 3,
  parameter  int DATA_LEN  = 1,
  localparam int NREQ      = NUM_DMA + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [Q_W-1:0]     cfgQuantum,
  input  logic [O_W-1:0]     cfgOverhead,
  input  logic [NREQ-1:0]    reqVec,
  input  logic [NUM_DMA-1:0] dmaDone,
  output logic [NREQ-1:0]    grantVec,
  output logic               busOverhead,
  output logic               busPayload,
  output logic [CNT_W-1:0]   overheadCount,
  output logic [CNT_W-1:0]   payloadCount
);

  ctl_strobe_t strobe;
  logic        remLast;

  qarb_control #(.NUM_DMA(NUM_DMA), .O_W(O_W)) control_i (
    .clk         (clk),
    .rstN        (rstN),
    .cfgOverhead (cfgOverhead),
    .reqVec      (reqVec),
    .dmaDone     (dmaDone),
    .remLast     (remLast),
    .strobe      (strobe),
    .grantVec    (grantVec),
    .busOverhead (busOverhead),
    .busPayload  (busPayload)
  );

  qarb_datapath #(
    .Q_W(Q_W), .O_W(O_W), .CNT_W(CNT_W),
    .FETCH_LEN(FETCH_LEN), .DATA_LEN(DATA_LEN)
  ) datapath_i (
    .clk           (clk),
    .rstN          (rstN),
    .cfgQuantum    (cfgQuantum),
    .cfgOverhead   (cfgOverhead),
    .strobe        (strobe),
    .remLast       (remLast),
    .overheadCount (overheadCount),
    .payloadCount  (payloadCount)
  );

  // R9: idle cycles leave both counters unchanged
  a_r9_idle_uncounted: assert property (@(posedge clk) disable iff (!rstN)
    (grantVec == '0) |=> (overheadCount == $past(overheadCount)) &&
                         (payloadCount == $past(payloadCount)));

endmodule

// File: tb/quantum_bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module quantum_bus_arbiter_tb_top;

  localparam int NUM_DMA = 2;
  localparam int NREQ    = NUM_DMA + 2;

  logic               clk = 1'b0;
  logic               rstN;
  logic [3:0]         cfgQuantum;
  logic [3:0]         cfgOverhead;
  logic [NREQ-1:0]    reqVec;
  logic [NUM_DMA-1:0] dmaDone;
  logic [NREQ-1:0]    grantVec;
  logic               busOverhead, busPayload;
  logic [15:0]        overheadCount, payloadCount;

  int nChecks = 0;
  int nFail   = 0;
  logic [NREQ-1:0] seqLog [8];
  int nSeq, gapCyc;

  // Fields: idx, quantum, overhead, doneAt (0 = never), expOvh, expPay
  localparam logic [23:0] VECS [8] = '{
    24'h042023, 24'h021012, 24'h142021, 24'h251015,
    24'h362323, 24'h200001, 24'h003031, 24'h3F0101
  };

  always #2 clk = ~clk;

  quantum_bus_arbiter dut_i (
    .clk(clk), .rstN(rstN), .cfgQuantum(cfgQuantum), .cfgOverhead(cfgOverhead),
    .reqVec(reqVec), .dmaDone(dmaDone), .grantVec(grantVec),
    .busOverhead(busOverhead), .busPayload(busPayload),
    .overheadCount(overheadCount), .payloadCount(payloadCount)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drain();
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (grantVec == '0) break;
    end
  endtask

  task automatic observe(input int cycles, input bit dropReq);
    logic [NREQ-1:0] prevG;
    int idleRun;
    nSeq = 0; gapCyc = 0; prevG = '0; idleRun = 0;
    for (int t = 0; t < cycles; t++) begin
      @(negedge clk);
      if (grantVec != '0) begin
        if (grantVec != prevG) begin
          if (nSeq > 0) gapCyc += idleRun;
          if (nSeq < 8) seqLog[nSeq] = grantVec;
          nSeq++;
        end
        idleRun = 0;
        if (dropReq) reqVec = reqVec & ~grantVec;
      end else begin
        idleRun++;
      end
      prevG = grantVec;
    end
  endtask

  task automatic runOne(input int v, input int idx, input int q, input int o,
                        input int doneAt, input int expO, input int expP);
    int po, pp, g;
    bit seen;
    logic [15:0] o0, p0;
    cfgQuantum = 4'(q); cfgOverhead = 4'(o);
    @(negedge clk);
    o0 = overheadCount; p0 = payloadCount;
    reqVec[idx] = 1'b1;
    seen = 0; po = 0; pp = 0; g = 0;
    for (int t = 0; t < 100; t++) begin
      @(negedge clk);
      if (grantVec[idx]) begin
        g++;
        if (!seen) begin seen = 1; reqVec[idx] = 1'b0; end
        if (busOverhead) po++;
        if (busPayload) pp++;
        if (idx >= 2) dmaDone[idx-2] = busPayload && (pp == doneAt);
      end else if (seen) begin
        break;
      end
    end
    dmaDone = '0;
    check($sformatf("R1 vec%0d handshake cycles", v), po, expO);
    check($sformatf("R2 vec%0d payload cycles", v), pp, expP);
    check($sformatf("R4/R6 vec%0d grant length", v), g, expO + expP);
    check($sformatf("R9 vec%0d overhead delta", v), int'(16'(overheadCount - o0)), expO);
    check($sformatf("R9 vec%0d payload delta", v), int'(16'(payloadCount - p0)), expP);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqVec = '0; dmaDone = '0;
    cfgQuantum = 4'd2; cfgOverhead = 4'd1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 grant in reset", int'(grantVec), 0);
    check("R10 phases in reset", int'({busOverhead, busPayload}), 0);
    check("R10 overhead count in reset", int'(overheadCount), 0);
    check("R10 payload count in reset", int'(payloadCount), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector table: single requester grants
    for (int v = 0; v < 8; v++) begin
      runOne(v, int'(VECS[v][23:20]), int'(VECS[v][19:16]), int'(VECS[v][15:12]),
             int'(VECS[v][11:8]), int'(VECS[v][7:4]), int'(VECS[v][3:0]));
    end

    // R3 priority with fetch, data and DMA0 together from idle
    cfgQuantum = 4'd2; cfgOverhead = 4'd1;
    @(negedge clk); reqVec = 4'b0111;
    observe(12, 1'b1);
    check("R3 first winner data", int'(seqLog[0]), 2);
    check("R3 second winner dma0", int'(seqLog[1]), 4);
    check("R3 third winner fetch", int'(seqLog[2]), 1);
    check("R8 back-to-back handover gaps", gapCyc, 0);
    drain();

    // R8 expired owner waits behind fetch while still requesting
    reqVec = 4'b0101;
    observe(9, 1'b0);
    check("R8 expiry first dma0", int'(seqLog[0]), 4);
    check("R8 expiry then fetch", int'(seqLog[1]), 1);
    check("R8 expiry then dma0 again", int'(seqLog[2]), 4);
    reqVec = '0; drain();

    // R8 sole requester re-requests: one idle cycle
    reqVec = 4'b0100;
    observe(8, 1'b0);
    check("R8 sole requester regranted", int'(seqLog[1]), 4);
    check("R8 sole requester idle gap", gapCyc, 1);
    reqVec = '0; drain();

    // R7 rotation among DMA engines
    reqVec = 4'b1000; observe(5, 1'b1); drain();
    reqVec = 4'b1100; observe(10, 1'b1);
    check("R7 after dma1 served, dma0 first", int'(seqLog[0]), 4);
    drain();
    reqVec = 4'b0100; observe(5, 1'b1); drain();
    reqVec = 4'b1100; observe(10, 1'b1);
    check("R7 after dma0 served, dma1 first", int'(seqLog[0]), 8);
    drain();

    // R6 completion during handshake is ignored
    begin
      int po, pp;
      bit seen;
      cfgQuantum = 4'd4; cfgOverhead = 4'd3;
      @(negedge clk); reqVec = 4'b0100;
      po = 0; pp = 0; seen = 0;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (grantVec[2]) begin
          if (!seen) begin seen = 1; reqVec = '0; end
          if (busOverhead) po++;
          if (busPayload) pp++;
          dmaDone[0] = busOverhead;
        end else if (seen) begin
          break;
        end
      end
      dmaDone = '0;
      check("R6 handshake done ignored, payload", pp, 4);
      check("R1 handshake length with done held", po, 3);
    end

    // R6 done from a non-granted engine is ignored
    begin
      int pp;
      bit seen;
      cfgQuantum = 4'd3; cfgOverhead = 4'd0;
      @(negedge clk); reqVec = 4'b0100;
      pp = 0; seen = 0;
      for (int t = 0; t < 40; t++) begin
        @(negedge clk);
        if (grantVec[2]) begin
          if (!seen) begin seen = 1; reqVec = '0; end
          if (busPayload) pp++;
          dmaDone[1] = 1'b1;
        end else if (seen) begin
          break;
        end
      end
      dmaDone = '0;
      check("R6 other engine done ignored", pp, 3);
    end

    // R9 idle cycles do not count
    begin
      logic [15:0] o0, p0;
      drain();
      o0 = overheadCount; p0 = payloadCount;
      repeat (10) @(negedge clk);
      check("R9 idle overhead unchanged", int'(overheadCount), int'(o0));
      check("R9 idle payload unchanged", int'(payloadCount), int'(p0));
      check("R5 no grant while idle", int'(grantVec), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule